// File: doc/BRIEF.md
# Multi-Track Sector Transfer Sequencer

This block steps a disk read or write command through a run of sectors on one cylinder. It also gives the data path the number of bytes to move in each sector. A start pulse captures the command parameters: the multi-track flag, the starting head and sector, the end-of-track sector number, the sector size code and the short-sector data length. The data path then sends one strobe for each byte it transfers. The sequencer counts each sector down to zero, signals when the byte budget is used up, and moves to the next sector address. The run ends at the end of the track or when a terminate request is seen.

When the multi-track flag is set and the run starts on head 0, the two sides of the cylinder act as one long track. After the end-of-track sector on head 0, the run continues on head 1 from the first sector and ends at the end-of-track sector there. Sectors are numbered from 1. The run is assumed to start at or below the end-of-track number.

Top module: `sector_run_seq`

## Requirements
- R1: After reset, `busy`, `cmd_done`, `count_hit` and `sector_done` are 0.
- R2: When idle, a `start` pulse loads `head` and `sector` from the start inputs and raises `busy` on the following clock. A `start` pulse while `busy` is high changes neither the address nor the run.
- R3: For a size code N from 1 to 7, each sector takes 128·2^N byte strobes. Codes above 7 behave as code 7, which is 16384 strobes.
- R4: For size code 0, each sector takes `data_len` strobes. A `data_len` of 0 means 256 strobes.
- R5: `count_hit` is high for exactly one clock, in the cycle after the edge that accepts the sector's final strobe. Strobes during that cycle are not counted.
- R6: `sector_done` is high for exactly one clock, in the cycle after `count_hit`. If the run continues, the next sector starts with a full byte budget in that same cycle.
- R7: Inside a track, the next sector address is the previous sector number plus 1, on the same head.
- R8: With `multi_trk` at 0, the run ends when the end-of-track sector on the starting head is done.
- R9: With `multi_trk` at 1 and a start on head 0, the end-of-track sector on head 0 is followed by sector 1 on head 1. The run ends after the end-of-track sector on head 1.
- R10: With `multi_trk` at 1 and a start on head 1, the run ends after the end-of-track sector on head 1 and never goes back to head 0.
- R11: A `terminate` pulse during a run ends it when the current sector completes. A `terminate` pulse while idle has no effect on the next run.
- R12: At the end of a run, `cmd_done` rises in the same cycle as the final `sector_done` pulse and `busy` falls. `head` and `sector` keep the last sector's address, and `cmd_done` stays high until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a command with the parameters present on the inputs |
| multi_trk | input | 1 | 1: continue from head 0 to head 1 across the cylinder |
| start_head | input | 1 | Starting head, i.e. disk side |
| start_sector | input | SEC_W | Starting sector number (1-based) |
| eot_sector | input | SEC_W | Last sector number on each track |
| size_code | input | CODE_W | Sector size code |
| data_len | input | DL_W | Byte count per sector when the size code is 0 |
| xfer_stb | input | 1 | One byte moved by the data path |
| terminate | input | 1 | End the run at the next sector boundary |
| busy | output | 1 | A command is in progress |
| head | output | 1 | Current head address |
| sector | output | SEC_W | Current sector number |
| count_hit | output | 1 | The sector's byte budget is used up |
| sector_done | output | 1 | The sector has finished and the address has advanced |
| cmd_done | output | 1 | The command has finished |

## Verification
A start pulse sampled on one edge shows up in `busy`, `head` and `sector` after that edge. The final byte strobe of a sector produces `count_hit` after the edge that accepts it. `sector_done`, the new address and `cmd_done` follow one edge later. The bench drives inputs on falling edges and reads outputs on the falling edge after each relevant rising edge, so every check falls in the exact cycle these counts predict. It also checks the cycle just before each sector's final strobe. This catches a budget that is one byte short, and the cycle after, which catches a pulse that lasts longer than one clock.

// File: rtl/sector_run_pkg.sv
// Shared types for the sector run sequencer.
// Assumes: nothing beyond the 1800-2017 language.
package sector_run_pkg;

    // Sequencer phase: waiting, counting bytes, or at a sector boundary
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_XFER = 2'd1,
        PH_HIT  = 2'd2
    } seq_phase_t;

endpackage

// File: rtl/srs_budget.sv
// Per-sector byte budget from the size code and the short-sector length.
// What it does: code 0 picks data_len (0 means 256); codes 1..MAX_CODE give
//   BASE_BYTES << code; any code above MAX_CODE is clamped to MAX_CODE.
// Assumes: CNT_W is wide enough for BASE_BYTES << MAX_CODE and for 256.
module srs_budget #(
    parameter int CODE_W     = 8,
    parameter int DL_W       = 8,
    parameter int MAX_CODE   = 7,
    parameter int BASE_BYTES = 128,
    parameter int CNT_W      = 15
) (
    input  logic [CODE_W-1:0] size_code,
    input  logic [DL_W-1:0]   data_len,
    output logic [CNT_W-1:0]  budget
);
    localparam int SEL_W = $clog2(MAX_CODE + 1);

    logic [SEL_W-1:0] eff_code;

    // Clamp the size code to the largest supported value
    always_comb begin
        if (size_code > CODE_W'(MAX_CODE))
            eff_code = SEL_W'(MAX_CODE);
        else
            eff_code = size_code[SEL_W-1:0];
    end

    // Choose between the short-sector length and the power-of-two size
    always_comb begin
        if (eff_code == '0) begin
            if (data_len == '0)
                budget = CNT_W'(256);
            else
                budget = CNT_W'(data_len);
        end else begin
            budget = CNT_W'(BASE_BYTES) << eff_code;
        end
    end
endmodule

// File: rtl/srs_byte_ctr.sv
// Down counter holding the bytes left in the current sector.
// What it does: load wins over decrement; it never goes below zero.
// Assumes: the loaded value is at least 1.
module srs_byte_ctr #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             last_byte
);
    logic [CNT_W-1:0] remaining;

    // Reload at a sector start, otherwise count accepted strobes down
    always_ff @(posedge clk) begin
        if (!rst_n)
            remaining <= '0;
        else if (load)
            remaining <= load_val;
        else if (dec && remaining != '0)
            remaining <= remaining - 1'b1;
    end

    // The next accepted strobe finishes the sector
    assign last_byte = (remaining == CNT_W'(1));
endmodule

// File: rtl/srs_addr_step.sv
// Next head and sector address, and end-of-run detection.
// What it does: inside a track the sector goes up by one. At end-of-track on
//   head 0 in multi-track mode it moves to FIRST_SEC on head 1. Any other
//   end-of-track ends the run.
// Assumes: the run started at or below the end-of-track sector.
module srs_addr_step #(
    parameter int SEC_W     = 8,
    parameter int FIRST_SEC = 1
) (
    input  logic             multi_trk,
    input  logic             head,
    input  logic [SEC_W-1:0] sector,
    input  logic [SEC_W-1:0] eot,
    output logic             nxt_head,
    output logic [SEC_W-1:0] nxt_sector,
    output logic             run_end
);
    logic at_eot;

    // Compare the current sector with the end of the track
    assign at_eot = (sector == eot);

    // Work out the following address and whether the run stops here
    always_comb begin
        run_end = at_eot && !(multi_trk && !head);
        if (at_eot) begin
            nxt_head   = 1'b1;
            nxt_sector = SEC_W'(FIRST_SEC);
        end else begin
            nxt_head   = head;
            nxt_sector = sector + 1'b1;
        end
    end
endmodule

// File: rtl/sector_run_seq.sv
// Top level of the multi-track sector transfer sequencer.
// What it does: captures a command on start, counts each sector's byte
//   budget down with xfer_stb, and moves the address on at every sector
//   boundary until end-of-track or terminate.
// Assumes: the byte strobe comes from a data path in the same clock domain.
module sector_run_seq
    import sector_run_pkg::*;
#(
    parameter int SEC_W      = 8,
    parameter int CODE_W     = 8,
    parameter int DL_W       = 8,
    parameter int MAX_CODE   = 7,
    parameter int BASE_BYTES = 128,
    parameter int FIRST_SEC  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              multi_trk,
    input  logic              start_head,
    input  logic [SEC_W-1:0]  start_sector,
    input  logic [SEC_W-1:0]  eot_sector,
    input  logic [CODE_W-1:0] size_code,
    input  logic [DL_W-1:0]   data_len,
    input  logic              xfer_stb,
    input  logic              terminate,
    output logic              busy,
    output logic              head,
    output logic [SEC_W-1:0]  sector,
    output logic              count_hit,
    output logic              sector_done,
    output logic              cmd_done
);
    localparam int CNT_W = $clog2(BASE_BYTES) + MAX_CODE + 1;

    seq_phase_t       phase;
    logic             mt_q;
    logic [SEC_W-1:0] eot_q;
    logic [CNT_W-1:0] budget_q;
    logic [CNT_W-1:0] budget_now;
    logic             term_pend;
    logic             last_byte;
    logic             nxt_head;
    logic [SEC_W-1:0] nxt_sector;
    logic             run_end;
    logic             ending;
    logic             ctr_load;
    logic [CNT_W-1:0] ctr_val;

    srs_budget #(
        .CODE_W(CODE_W), .DL_W(DL_W), .MAX_CODE(MAX_CODE),
        .BASE_BYTES(BASE_BYTES), .CNT_W(CNT_W)
    ) u_budget (
        .size_code(size_code),
        .data_len (data_len),
        .budget   (budget_now)
    );

    srs_addr_step #(.SEC_W(SEC_W), .FIRST_SEC(FIRST_SEC)) u_step (
        .multi_trk (mt_q),
        .head      (head),
        .sector    (sector),
        .eot       (eot_q),
        .nxt_head  (nxt_head),
        .nxt_sector(nxt_sector),
        .run_end   (run_end)
    );

    srs_byte_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ctr_load),
        .load_val (ctr_val),
        .dec      (phase == PH_XFER && xfer_stb),
        .last_byte(last_byte)
    );

    // A sector boundary that stops the run
    assign ending = run_end || term_pend || terminate;

    // Reload the counter at command start and at each continuing boundary
    always_comb begin
        ctr_load = (phase == PH_IDLE && start) || (phase == PH_HIT && !ending);
        ctr_val  = (phase == PH_IDLE) ? budget_now : budget_q;
    end

    // Status seen by the data path
    assign busy      = (phase != PH_IDLE);
    assign count_hit = (phase == PH_HIT);

    // Command phase, address and completion state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase       <= PH_IDLE;
            mt_q        <= 1'b0;
            eot_q       <= '0;
            budget_q    <= '0;
            head        <= 1'b0;
            sector      <= '0;
            term_pend   <= 1'b0;
            sector_done <= 1'b0;
            cmd_done    <= 1'b0;
        end else begin
            sector_done <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    term_pend <= 1'b0;
                    if (start) begin
                        phase    <= PH_XFER;
                        mt_q     <= multi_trk;
                        eot_q    <= eot_sector;
                        budget_q <= budget_now;
                        head     <= start_head;
                        sector   <= start_sector;
                        cmd_done <= 1'b0;
                    end
                end
                PH_XFER: begin
                    if (terminate)
                        term_pend <= 1'b1;
                    if (xfer_stb && last_byte)
                        phase <= PH_HIT;
                end
                PH_HIT: begin
                    sector_done <= 1'b1;
                    if (ending) begin
                        phase     <= PH_IDLE;
                        cmd_done  <= 1'b1;
                        term_pend <= 1'b0;
                    end else begin
                        phase  <= PH_XFER;
                        head   <= nxt_head;
                        sector <= nxt_sector;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/srs_checker.sv
// Timing and sequencing properties of sector_run_seq, bound to every instance.
// Assumes: it sees only the top module's ports.
module srs_checker #(
    parameter int SEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             head,
    input logic [SEC_W-1:0] sector,
    input logic             count_hit,
    input logic             sector_done,
    input logic             cmd_done
);
    // R5
    hit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_hit |=> !count_hit);

    // R6
    done_follows_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_hit |=> sector_done);

    // R6
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sector_done |=> !sector_done);

    // R12
    cmd_with_sector_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_done) |-> (sector_done && !busy));

    // R10
    no_head_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && $past(head)) |-> head);

    // R7
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sector_done && busy) |->
            ((sector == SEC_W'($past(sector) + 1'b1) && head == $past(head)) ||
             (sector == SEC_W'(1) && head && !$past(head))));
endmodule

bind sector_run_seq srs_checker #(.SEC_W(SEC_W)) u_srs_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .head       (head),
    .sector     (sector),
    .count_hit  (count_hit),
    .sector_done(sector_done),
    .cmd_done   (cmd_done)
);

// File: tb/test_sector_run_seq.sv
`timescale 1ns/1ps
// Directed bench for sector_run_seq: one task per scenario.
module test_sector_run_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       multi_trk = 1'b0;
    logic       start_head = 1'b0;
    logic [7:0] start_sector = '0;
    logic [7:0] eot_sector = '0;
    logic [7:0] size_code = '0;
    logic [7:0] data_len = '0;
    logic       xfer_stb = 1'b0;
    logic       terminate = 1'b0;
    logic       busy, head, count_hit, sector_done, cmd_done;
    logic [7:0] sector;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    sector_run_seq i_sector_run_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .multi_trk(multi_trk),
        .start_head(start_head), .start_sector(start_sector),
        .eot_sector(eot_sector), .size_code(size_code), .data_len(data_len),
        .xfer_stb(xfer_stb), .terminate(terminate), .busy(busy), .head(head),
        .sector(sector), .count_hit(count_hit), .sector_done(sector_done),
        .cmd_done(cmd_done)
    );

    // 200 MHz clock
    always #2.5 clk = ~clk;

    // Record one check and report it if it fails
    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Issue a command and confirm that it was captured
    task automatic do_start(input bit mt, input bit h, input int s, input int e,
                            input int code, input int dl);
        @(negedge clk);
        multi_trk = mt; start_head = h; start_sector = 8'(s);
        eot_sector = 8'(e); size_code = 8'(code); data_len = 8'(dl);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
        check(head == h, "R2", "start head", int'(head), int'(h));
        check(int'(sector) == s, "R2", "start sector", int'(sector), s);
    endtask

    // Move one sector of n bytes and check the boundary timing
    task automatic run_sector(input int n, input bit eh, input int es,
                              input bit last, input string req);
        check(head == eh, req, "head", int'(head), int'(eh));
        check(int'(sector) == es, req, "sector", int'(sector), es);
        @(negedge clk);
        xfer_stb = 1'b1;
        repeat (n - 1) @(negedge clk);
        check(count_hit == 1'b0, req, "count_hit before final byte", int'(count_hit), 0);
        @(negedge clk);
        xfer_stb = 1'b0;
        check(count_hit == 1'b1, "R5", "count_hit after final byte", int'(count_hit), 1);
        @(negedge clk);
        check(sector_done == 1'b1, "R6", "sector_done", int'(sector_done), 1);
        check(count_hit == 1'b0, "R5", "count_hit width", int'(count_hit), 0);
        check(cmd_done == last, req, "cmd_done", int'(cmd_done), int'(last));
        check(busy == !last, "R12", "busy", int'(busy), int'(!last));
        if (last) begin
            check(head == eh, "R12", "held head", int'(head), int'(eh));
            check(int'(sector) == es, "R12", "held sector", int'(sector), es);
        end
    endtask

    // Scenario: reset state (R1)
    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R1", "busy", int'(busy), 0);
        check(cmd_done == 1'b0, "R1", "cmd_done", int'(cmd_done), 0);
        check(count_hit == 1'b0, "R1", "count_hit", int'(count_hit), 0);
        check(sector_done == 1'b0, "R1", "sector_done", int'(sector_done), 0);
    endtask

    // Scenario: single track, short sectors (R4, R7, R8, R12)
    task automatic t_single_track;
        do_start(1'b0, 1'b0, 2, 4, 0, 3);
        run_sector(3, 1'b0, 2, 1'b0, "R7");
        run_sector(3, 1'b0, 3, 1'b0, "R7");
        run_sector(3, 1'b0, 4, 1'b1, "R8");
        repeat (4) @(negedge clk);
        check(cmd_done == 1'b1, "R12", "cmd_done persists", int'(cmd_done), 1);
    endtask

    // Scenario: multi-track roll from head 0 to head 1 (R9)
    task automatic t_multi_wrap;
        do_start(1'b1, 1'b0, 3, 4, 0, 2);
        check(cmd_done == 1'b0, "R12", "cmd_done cleared by start", int'(cmd_done), 0);
        run_sector(2, 1'b0, 3, 1'b0, "R9");
        run_sector(2, 1'b0, 4, 1'b0, "R9");
        run_sector(2, 1'b1, 1, 1'b0, "R9");
        run_sector(2, 1'b1, 2, 1'b0, "R9");
        run_sector(2, 1'b1, 3, 1'b0, "R9");
        run_sector(2, 1'b1, 4, 1'b1, "R9");
    endtask

    // Scenario: multi-track starting on head 1 (R10)
    task automatic t_multi_head1;
        do_start(1'b1, 1'b1, 3, 4, 0, 1);
        run_sector(1, 1'b1, 3, 1'b0, "R10");
        run_sector(1, 1'b1, 4, 1'b1, "R10");
    endtask

    // Scenario: terminate mid-run, then terminate while idle (R11)
    task automatic t_terminate;
        do_start(1'b1, 1'b0, 1, 3, 0, 2);
        run_sector(2, 1'b0, 1, 1'b0, "R11");
        @(negedge clk);
        terminate = 1'b1;
        @(negedge clk);
        terminate = 1'b0;
        run_sector(2, 1'b0, 2, 1'b1, "R11");
        @(negedge clk);
        terminate = 1'b1;
        @(negedge clk);
        terminate = 1'b0;
        do_start(1'b0, 1'b0, 1, 2, 0, 1);
        run_sector(1, 1'b0, 1, 1'b0, "R11");
        run_sector(1, 1'b0, 2, 1'b1, "R11");
    endtask

    // Scenario: start while busy has no effect (R2)
    task automatic t_start_busy;
        do_start(1'b0, 1'b0, 1, 2, 0, 2);
        @(negedge clk);
        start_head = 1'b1; start_sector = 8'd7; data_len = 8'd9; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(head == 1'b0, "R2", "head after busy start", int'(head), 0);
        check(int'(sector) == 1, "R2", "sector after busy start", int'(sector), 1);
        run_sector(2, 1'b0, 1, 1'b0, "R2");
        run_sector(2, 1'b0, 2, 1'b1, "R2");
    endtask

    // Scenario: strobes during count_hit are dropped (R5, R6)
    task automatic t_hit_ignore;
        do_start(1'b0, 1'b0, 1, 2, 0, 4);
        @(negedge clk);
        xfer_stb = 1'b1;
        repeat (4) @(negedge clk);
        check(count_hit == 1'b1, "R5", "count_hit", int'(count_hit), 1);
        @(negedge clk);
        xfer_stb = 1'b0;
        check(sector_done == 1'b1, "R6", "sector_done", int'(sector_done), 1);
        run_sector(4, 1'b0, 2, 1'b1, "R6");
    endtask

    // Scenario: size-code budgets, including the zero length and clamp (R3, R4)
    task automatic t_budgets;
        do_start(1'b0, 1'b0, 5, 5, 0, 0);
        run_sector(256, 1'b0, 5, 1'b1, "R4");
        do_start(1'b0, 1'b1, 6, 6, 1, 9);
        run_sector(256, 1'b1, 6, 1'b1, "R3");
        do_start(1'b0, 1'b0, 7, 7, 2, 9);
        run_sector(512, 1'b0, 7, 1'b1, "R3");
        do_start(1'b0, 1'b0, 8, 8, 9, 9);
        run_sector(16384, 1'b0, 8, 1'b1, "R3");
    endtask

    // Run the scenarios in order
    initial begin
        t_reset();
        t_single_track();
        t_multi_wrap();
        t_multi_head1();
        t_terminate();
        t_start_busy();
        t_hit_ignore();
        t_budgets();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule